// File: doc/BRIEF.md
# Flash wear and health manager

This block sits inside a flash storage controller and keeps the wear and health state for a small array of erase blocks. It counts the erases on each block, hands out free blocks from a single spare pool that spans the whole array, and follows the corrected-bit-error count that the ECC engine reports on each read. From this state it decides when data must be moved. A freshly allocated block that is already worn gets the contents of the least-worn block that still holds data. A block whose reads show a moderate error level is rewritten in place. A block whose error level is high is emptied and marked bad for good.

The block does not move any data itself. Each action leaves on one request channel, which carries a kind code, a target block and, for a swap, a source block. The channel holds one request at a time, and the data mover acknowledges it. A background scan, started by each erase, keeps a pointer to the least-erased block that holds data. The wear check uses that pointer as the swap source.

Top module: `flash_wear_mgr`

## Requirements
- R1: An active-low asynchronous reset clears every erase count, every bad flag, the pending request, the allocation outputs and the static-pointer valid flag, and puts every block into the spare pool.
- R2: An erase event adds one to that block's erase count, which saturates at 2^CNT_W-1 and does not wrap. The erase also returns the block to the spare pool.
- R3: One cycle after alloc_req_i, alloc_vld_o rises with alloc_blk_o set to the lowest-index block that is spare and not bad, and that block leaves the pool. If no such block exists, alloc_fail_o rises instead.
- R4: A block whose bad flag is set is never returned by an allocation, and its bad flag stays set until reset.
- R5: Each erase restarts a scan of NUM_BLOCKS cycles. The pointer commits NUM_BLOCKS cycles after the erase edge. It names the block with the lowest erase count among blocks that are neither spare nor bad, and ties go to the lower index. If no such block exists, static_vld_o is 0.
- R6: When an allocation returns a block whose count is strictly above WEAR_THRESH and the static pointer is valid, a swap request (kind 0) is raised in the same cycle as alloc_vld_o. Its target is the allocated block and its source is the static pointer. A count equal to WEAR_THRESH raises nothing.
- R7: A read whose error count is at least REFRESH_THRESH and below RETIRE_THRESH raises a refresh request (kind 1) for the read block one cycle later.
- R8: A read whose error count is at least RETIRE_THRESH sets the block's bad flag and raises a retire request (kind 2), never a refresh. Retire takes precedence over a refresh or swap raised in the same cycle.
- R9: While req_vld_o is high, its kind, block and source do not change until req_ack_i. Any request condition that arises while a request is pending, including the acknowledge cycle, is dropped. A bad flag is still set in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| erase_vld_i | input | 1 | An erase of erase_blk_i completed |
| erase_blk_i | input | BLK_W | Erased block index |
| alloc_req_i | input | 1 | Take one block from the spare pool |
| alloc_vld_o | output | 1 | Allocation result valid |
| alloc_fail_o | output | 1 | Allocation found no usable spare block |
| alloc_blk_o | output | BLK_W | Allocated block index |
| rd_vld_i | input | 1 | Read result from the ECC engine valid |
| rd_blk_i | input | BLK_W | Block that was read |
| rd_err_i | input | ERR_W | Corrected bit errors of that read |
| req_vld_o | output | 1 | Action request pending |
| req_kind_o | output | 2 | 0 swap, 1 refresh, 2 retire |
| req_blk_o | output | BLK_W | Target block of the request |
| req_src_o | output | BLK_W | Source block for a swap |
| req_ack_i | input | 1 | Data mover accepts the pending request |
| static_vld_o | output | 1 | Static pointer holds a block |
| static_ptr_o | output | BLK_W | Least-erased in-use block |

## Verification
The bench sets the erase count exactly at the wear threshold and one step above it. A strict/non-strict mix-up then shows up as a spurious or missing swap. It pushes one block's count past the counter limit, so a counter that wraps lets a worn block through with no swap. It retires a block while a refresh is pending, then erases that block and allocates. A design that lost the bad flag on a dropped request, or that handed out bad spares, returns that block instead of the next higher one. It also checks that the pointer skips a retired in-use block and that tied counts resolve to the lower index.

// File: rtl/flash_wear_pkg.sv
package flash_wear_pkg;
  typedef enum logic [1:0] {
    KIND_SWAP    = 2'd0,
    KIND_REFRESH = 2'd1,
    KIND_RETIRE  = 2'd2
  } req_kind_e;
endpackage

// File: rtl/fwm_block_table.sv
module fwm_block_table #(
  parameter int NUM_BLOCKS = 8,
  parameter int CNT_W      = 6,
  parameter int BLK_W      = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              erase_vld_i,
  input  logic [BLK_W-1:0]                  erase_blk_i,
  input  logic                              take_vld_i,
  input  logic [BLK_W-1:0]                  take_blk_i,
  input  logic                              bad_set_i,
  input  logic [BLK_W-1:0]                  bad_blk_i,
  output logic [NUM_BLOCKS-1:0][CNT_W-1:0]  cnt_o,
  output logic [NUM_BLOCKS-1:0]             bad_o,
  output logic [NUM_BLOCKS-1:0]             spare_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    logic hit_erase, hit_take, hit_bad;
    assign hit_erase = erase_vld_i && (erase_blk_i == BLK_W'(g));
    assign hit_take  = take_vld_i  && (take_blk_i  == BLK_W'(g));
    assign hit_bad   = bad_set_i   && (bad_blk_i   == BLK_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_o[g]   <= '0;
        bad_o[g]   <= 1'b0;
        spare_o[g] <= 1'b1;
      end else begin
        if (hit_erase) begin
          if (cnt_o[g] != CntMax) cnt_o[g] <= cnt_o[g] + CNT_W'(1);
          spare_o[g] <= 1'b1;
        end
        // taking wins over a same-cycle erase
        if (hit_take) spare_o[g] <= 1'b0;
        if (hit_bad)  bad_o[g]   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fwm_spare_picker.sv
module fwm_spare_picker #(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_W      = 3
) (
  input  logic [NUM_BLOCKS-1:0] spare_i,
  input  logic [NUM_BLOCKS-1:0] bad_i,
  output logic                  pick_vld_o,
  output logic [BLK_W-1:0]      pick_idx_o
);
  always_comb begin
    pick_vld_o = 1'b0;
    pick_idx_o = '0;
    for (int i = NUM_BLOCKS - 1; i >= 0; i--) begin
      if (spare_i[i] && !bad_i[i]) begin
        pick_vld_o = 1'b1;
        pick_idx_o = BLK_W'(i);
      end
    end
  end
endmodule

// File: rtl/fwm_static_scan.sv
module fwm_static_scan #(
  parameter int NUM_BLOCKS = 8,
  parameter int CNT_W      = 6,
  parameter int BLK_W      = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [NUM_BLOCKS-1:0][CNT_W-1:0]  cnt_i,
  input  logic [NUM_BLOCKS-1:0]             bad_i,
  input  logic [NUM_BLOCKS-1:0]             spare_i,
  output logic                              ptr_vld_o,
  output logic [BLK_W-1:0]                  ptr_o
);
  localparam logic [BLK_W-1:0] LastIdx = BLK_W'(NUM_BLOCKS - 1);

  logic             busy_q;
  logic [BLK_W-1:0] idx_q;
  logic             best_vld_q, nb_vld;
  logic [BLK_W-1:0] best_idx_q, nb_idx;
  logic [CNT_W-1:0] best_cnt_q, nb_cnt;
  logic             cand_ok, cand_win;

  assign cand_ok  = !bad_i[idx_q] && !spare_i[idx_q];
  assign cand_win = cand_ok && (!best_vld_q || (cnt_i[idx_q] < best_cnt_q));

  always_comb begin
    nb_vld = best_vld_q;
    nb_idx = best_idx_q;
    nb_cnt = best_cnt_q;
    if (cand_win) begin
      nb_vld = 1'b1;
      nb_idx = idx_q;
      nb_cnt = cnt_i[idx_q];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      idx_q      <= '0;
      best_vld_q <= 1'b0;
      best_idx_q <= '0;
      best_cnt_q <= '0;
      ptr_vld_o  <= 1'b0;
      ptr_o      <= '0;
    end else if (start_i) begin
      busy_q     <= 1'b1;
      idx_q      <= '0;
      best_vld_q <= 1'b0;
    end else if (busy_q) begin
      best_vld_q <= nb_vld;
      best_idx_q <= nb_idx;
      best_cnt_q <= nb_cnt;
      if (idx_q == LastIdx) begin
        busy_q    <= 1'b0;
        ptr_vld_o <= nb_vld;
        ptr_o     <= nb_idx;
      end else begin
        idx_q <= idx_q + BLK_W'(1);
      end
    end
  end
endmodule

// File: rtl/fwm_req_ctrl.sv
module fwm_req_ctrl
  import flash_wear_pkg::*;
#(
  parameter int BLK_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic             refresh_i,
  input  logic [BLK_W-1:0] rd_blk_i,
  input  logic             swap_i,
  input  logic [BLK_W-1:0] swap_dst_i,
  input  logic [BLK_W-1:0] swap_src_i,
  input  logic             ack_i,
  output logic             vld_o,
  output req_kind_e        kind_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [BLK_W-1:0] src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      kind_o <= KIND_SWAP;
      blk_o  <= '0;
      src_o  <= '0;
    end else if (vld_o) begin
      // pending: new conditions are dropped, also on the ack cycle
      if (ack_i) vld_o <= 1'b0;
    end else if (retire_i) begin
      vld_o  <= 1'b1;
      kind_o <= KIND_RETIRE;
      blk_o  <= rd_blk_i;
      src_o  <= '0;
    end else if (refresh_i) begin
      vld_o  <= 1'b1;
      kind_o <= KIND_REFRESH;
      blk_o  <= rd_blk_i;
      src_o  <= '0;
    end else if (swap_i) begin
      vld_o  <= 1'b1;
      kind_o <= KIND_SWAP;
      blk_o  <= swap_dst_i;
      src_o  <= swap_src_i;
    end
  end
endmodule

// File: rtl/flash_wear_mgr.sv
module flash_wear_mgr
  import flash_wear_pkg::*;
#(
  parameter int NUM_BLOCKS     = 8,
  parameter int CNT_W          = 6,
  parameter int ERR_W          = 6,
  parameter int WEAR_THRESH    = 20,
  parameter int REFRESH_THRESH = 8,
  parameter int RETIRE_THRESH  = 16,
  localparam int BLK_W         = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             erase_vld_i,
  input  logic [BLK_W-1:0] erase_blk_i,
  input  logic             alloc_req_i,
  output logic             alloc_vld_o,
  output logic             alloc_fail_o,
  output logic [BLK_W-1:0] alloc_blk_o,
  input  logic             rd_vld_i,
  input  logic [BLK_W-1:0] rd_blk_i,
  input  logic [ERR_W-1:0] rd_err_i,
  output logic             req_vld_o,
  output logic [1:0]       req_kind_o,
  output logic [BLK_W-1:0] req_blk_o,
  output logic [BLK_W-1:0] req_src_o,
  input  logic             req_ack_i,
  output logic             static_vld_o,
  output logic [BLK_W-1:0] static_ptr_o
);
  logic [NUM_BLOCKS-1:0][CNT_W-1:0] cnt_w;
  logic [NUM_BLOCKS-1:0]            bad_flags, spare_flags;
  logic                             pick_vld;
  logic [BLK_W-1:0]                 pick_idx;
  logic                             take_vld, retire_hit, refresh_hit, swap_hit;
  req_kind_e                        kind_w;

  assign take_vld    = alloc_req_i && pick_vld;
  assign retire_hit  = rd_vld_i && (rd_err_i >= ERR_W'(RETIRE_THRESH));
  assign refresh_hit = rd_vld_i && (rd_err_i >= ERR_W'(REFRESH_THRESH)) && !retire_hit;
  assign swap_hit    = take_vld && static_vld_o && (cnt_w[pick_idx] > CNT_W'(WEAR_THRESH));

  fwm_block_table #(.NUM_BLOCKS(NUM_BLOCKS), .CNT_W(CNT_W), .BLK_W(BLK_W)) u_table (
    .clk_i, .rst_ni,
    .erase_vld_i, .erase_blk_i,
    .take_vld_i (take_vld),
    .take_blk_i (pick_idx),
    .bad_set_i  (retire_hit),
    .bad_blk_i  (rd_blk_i),
    .cnt_o      (cnt_w),
    .bad_o      (bad_flags),
    .spare_o    (spare_flags)
  );

  fwm_spare_picker #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_picker (
    .spare_i    (spare_flags),
    .bad_i      (bad_flags),
    .pick_vld_o (pick_vld),
    .pick_idx_o (pick_idx)
  );

  fwm_static_scan #(.NUM_BLOCKS(NUM_BLOCKS), .CNT_W(CNT_W), .BLK_W(BLK_W)) u_scan (
    .clk_i, .rst_ni,
    .start_i   (erase_vld_i),
    .cnt_i     (cnt_w),
    .bad_i     (bad_flags),
    .spare_i   (spare_flags),
    .ptr_vld_o (static_vld_o),
    .ptr_o     (static_ptr_o)
  );

  fwm_req_ctrl #(.BLK_W(BLK_W)) u_req (
    .clk_i, .rst_ni,
    .retire_i   (retire_hit),
    .refresh_i  (refresh_hit),
    .rd_blk_i,
    .swap_i     (swap_hit),
    .swap_dst_i (pick_idx),
    .swap_src_i (static_ptr_o),
    .ack_i      (req_ack_i),
    .vld_o      (req_vld_o),
    .kind_o     (kind_w),
    .blk_o      (req_blk_o),
    .src_o      (req_src_o)
  );
  assign req_kind_o = kind_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_vld_o  <= 1'b0;
      alloc_fail_o <= 1'b0;
      alloc_blk_o  <= '0;
    end else begin
      alloc_vld_o  <= take_vld;
      alloc_fail_o <= alloc_req_i && !pick_vld;
      if (take_vld) alloc_blk_o <= pick_idx;
    end
  end
endmodule

// File: rtl/fwm_chk.sv
module fwm_chk #(
  parameter int NUM_BLOCKS    = 8,
  parameter int ERR_W         = 6,
  parameter int RETIRE_THRESH = 16,
  parameter int BLK_W         = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  rd_vld_i,
  input logic [BLK_W-1:0]      rd_blk_i,
  input logic [ERR_W-1:0]      rd_err_i,
  input logic                  req_vld_o,
  input logic                  req_ack_i,
  input logic [1:0]            req_kind_o,
  input logic [BLK_W-1:0]      req_blk_o,
  input logic [BLK_W-1:0]      req_src_o,
  input logic                  alloc_vld_o,
  input logic [BLK_W-1:0]      alloc_blk_o,
  input logic [NUM_BLOCKS-1:0] bad_q
);
  logic [NUM_BLOCKS-1:0] bad_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bad_d <= '0;
    else         bad_d <= bad_q;
  end

  logic hi_err;
  assign hi_err = rd_vld_i && (rd_err_i >= ERR_W'(RETIRE_THRESH));

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_o && !req_ack_i |=> req_vld_o && $stable(req_kind_o)
      && $stable(req_blk_o) && $stable(req_src_o));

  // R4
  alloc_not_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_vld_o |-> !bad_d[alloc_blk_o]);

  // R8
  retire_marks_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_err |=> bad_q[$past(rd_blk_i)]);

  // R8
  retire_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_err && !req_vld_o |=> req_vld_o && (req_kind_o == 2'd2)
      && (req_blk_o == $past(rd_blk_i)));

  // R6
  swap_distinct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_o && (req_kind_o == 2'd0) |-> req_src_o != req_blk_o);

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_sticky
    // R4
    bad_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad_q[g] |=> bad_q[g]);
  end
endmodule

bind flash_wear_mgr fwm_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .ERR_W(ERR_W), .RETIRE_THRESH(RETIRE_THRESH), .BLK_W(BLK_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .rd_vld_i(rd_vld_i), .rd_blk_i(rd_blk_i), .rd_err_i(rd_err_i),
  .req_vld_o(req_vld_o), .req_ack_i(req_ack_i), .req_kind_o(req_kind_o),
  .req_blk_o(req_blk_o), .req_src_o(req_src_o),
  .alloc_vld_o(alloc_vld_o), .alloc_blk_o(alloc_blk_o),
  .bad_q(bad_flags)
);

// File: tb/flash_wear_mgr_tb_top.sv
`timescale 1ns/1ps
module flash_wear_mgr_tb_top;
  localparam int N = 8, CW = 6, EW = 6, WEAR = 20, REF = 8, RET = 16, BW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic erase_vld = 0, alloc_req = 0, rd_vld = 0, ack = 0;
  logic [BW-1:0] erase_blk = '0, rd_blk = '0;
  logic [EW-1:0] rd_err = '0;
  logic alloc_vld, alloc_fail, req_vld, static_vld;
  logic [BW-1:0] alloc_blk, req_blk, req_src, static_ptr;
  logic [1:0] req_kind;

  always #10 clk = ~clk;

  flash_wear_mgr #(.NUM_BLOCKS(N), .CNT_W(CW), .ERR_W(EW), .WEAR_THRESH(WEAR),
    .REFRESH_THRESH(REF), .RETIRE_THRESH(RET)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .erase_vld_i(erase_vld), .erase_blk_i(erase_blk),
    .alloc_req_i(alloc_req), .alloc_vld_o(alloc_vld), .alloc_fail_o(alloc_fail),
    .alloc_blk_o(alloc_blk),
    .rd_vld_i(rd_vld), .rd_blk_i(rd_blk), .rd_err_i(rd_err),
    .req_vld_o(req_vld), .req_kind_o(req_kind), .req_blk_o(req_blk),
    .req_src_o(req_src), .req_ack_i(ack),
    .static_vld_o(static_vld), .static_ptr_o(static_ptr));

  int n_chk = 0, n_err = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // behavioural reference
  int  m_cnt[N];
  bit  m_bad[N], m_spare[N];
  bit  m_rv, m_av, m_af, m_pv;
  int  m_rk, m_rb, m_rs, m_ab, m_pp, m_scan;

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_bad[i] = 0; m_spare[i] = 1; end
    m_rv = 0; m_av = 0; m_af = 0; m_pv = 0; m_rk = 0; m_rb = 0; m_rs = 0;
    m_ab = 0; m_pp = 0; m_scan = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      int pk, best;
      bit ret, rfr, sw, was;
      pk = -1;
      for (int i = 0; i < N; i++) if (pk < 0 && m_spare[i] && !m_bad[i]) pk = i;
      ret = rd_vld && (int'(rd_err) >= RET);
      rfr = rd_vld && (int'(rd_err) >= REF) && !ret;
      sw  = alloc_req && pk >= 0 && m_pv && m_cnt[pk] > WEAR;
      was = m_rv;
      if (was) begin
        if (ack) m_rv = 0;
      end else if (ret) begin m_rv = 1; m_rk = 2; m_rb = int'(rd_blk); end
      else if (rfr) begin m_rv = 1; m_rk = 1; m_rb = int'(rd_blk); end
      else if (sw) begin m_rv = 1; m_rk = 0; m_rb = pk; m_rs = m_pp; end
      if (erase_vld) m_scan = N;
      else if (m_scan > 0) begin
        m_scan--;
        if (m_scan == 0) begin
          best = -1;
          for (int i = 0; i < N; i++)
            if (!m_bad[i] && !m_spare[i] && (best < 0 || m_cnt[i] < m_cnt[best])) best = i;
          m_pv = (best >= 0);
          if (best >= 0) m_pp = best;
        end
      end
      if (erase_vld) begin
        if (m_cnt[erase_blk] < CMAX) m_cnt[erase_blk]++;
        m_spare[erase_blk] = 1;
      end
      m_av = alloc_req && pk >= 0;
      m_af = alloc_req && pk < 0;
      if (m_av) begin m_spare[pk] = 0; m_ab = pk; end
      if (ret) m_bad[rd_blk] = 1;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) if (rst_n) begin
    chk(alloc_vld == m_av, "R3 alloc_vld", alloc_vld, m_av);
    chk(alloc_fail == m_af, "R3 alloc_fail", alloc_fail, m_af);
    if (m_av) chk(int'(alloc_blk) == m_ab, "R4 alloc_blk", alloc_blk, m_ab);
    chk(req_vld == m_rv, "R9 req_vld", req_vld, m_rv);
    if (m_rv) begin
      chk(int'(req_kind) == m_rk, "R8 req_kind", req_kind, m_rk);
      chk(int'(req_blk) == m_rb, "R7 req_blk", req_blk, m_rb);
      if (m_rk == 0) chk(int'(req_src) == m_rs, "R6 req_src", req_src, m_rs);
    end
    chk(static_vld == m_pv, "R5 static_vld", static_vld, m_pv);
    if (m_pv) chk(int'(static_ptr) == m_pp, "R5 static_ptr", static_ptr, m_pp);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_err++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic do_alloc(); alloc_req = 1; tick(); alloc_req = 0; endtask
  task automatic do_erase(input int b, input int n);
    for (int i = 0; i < n; i++) begin erase_vld = 1; erase_blk = BW'(b); tick(); end
    erase_vld = 0;
  endtask
  task automatic do_read(input int b, input int e);
    rd_vld = 1; rd_blk = BW'(b); rd_err = EW'(e); tick(); rd_vld = 0;
  endtask
  task automatic do_ack(); ack = 1; tick(); ack = 0; endtask
  task automatic wait_scan(); repeat (N + 2) tick(); endtask

  initial begin
    repeat (3) tick();
    expect_eq("R1 req_vld after reset", req_vld, 0);
    expect_eq("R1 static_vld after reset", static_vld, 0);
    rst_n = 1; tick();
    expect_eq("R1 alloc_vld after reset", alloc_vld, 0);

    do_alloc(); expect_eq("R3 first alloc", alloc_blk, 0);
    do_alloc(); expect_eq("R3 second alloc", alloc_blk, 1);
    do_alloc(); expect_eq("R3 third alloc", alloc_blk, 2);

    do_erase(0, 22); wait_scan();
    expect_eq("R5 ptr tie lowest index", static_ptr, 1);
    do_alloc();
    expect_eq("R3 reuse erased block", alloc_blk, 0);
    expect_eq("R6 swap raised", req_vld, 1);
    expect_eq("R6 swap kind", req_kind, 0);
    expect_eq("R6 swap src", req_src, 1);
    tick(); tick();
    expect_eq("R9 held without ack", req_vld, 1);
    do_ack(); expect_eq("R9 cleared by ack", req_vld, 0);

    do_erase(3, 20); wait_scan();
    do_alloc();
    expect_eq("R6 boundary alloc", alloc_blk, 3);
    expect_eq("R6 count equal to threshold no swap", req_vld, 0);

    do_read(1, REF - 1); expect_eq("R7 below refresh level", req_vld, 0);
    do_read(1, REF);
    expect_eq("R7 refresh raised", req_vld, 1);
    expect_eq("R7 refresh kind", req_kind, 1);
    do_read(2, RET);
    expect_eq("R9 retire dropped while pending", req_kind, 1);
    expect_eq("R9 pending block kept", req_blk, 1);
    do_ack();
    do_erase(2, 1); wait_scan();
    do_alloc(); expect_eq("R4 bad spare skipped", alloc_blk, 4);

    do_read(0, EW'(63));
    expect_eq("R8 retire kind", req_kind, 2);
    expect_eq("R8 retire block", req_blk, 0);
    do_ack();

    do_erase(1, 1); wait_scan();
    expect_eq("R5 ptr skips bad block", static_ptr, 4);

    do_erase(5, CMAX + 1); wait_scan();
    do_alloc(); expect_eq("R3 alloc lowest spare", alloc_blk, 1);
    expect_eq("R6 low count no swap", req_vld, 0);
    do_alloc(); expect_eq("R2 saturated block alloc", alloc_blk, 5);
    expect_eq("R2 saturated count still worn", req_vld, 1);
    expect_eq("R2 swap target", req_blk, 5);
    do_ack();

    do_alloc(); expect_eq("R3 alloc 6", alloc_blk, 6);
    do_alloc(); expect_eq("R3 alloc 7", alloc_blk, 7);
    do_alloc();
    expect_eq("R3 pool empty fail", alloc_fail, 1);
    expect_eq("R4 bad block withheld", alloc_vld, 0);

    rst_n = 0; tick();
    expect_eq("R1 req cleared", req_vld, 0);
    expect_eq("R1 pointer cleared", static_vld, 0);
    rst_n = 1; tick();
    do_alloc(); expect_eq("R1 bad flags cleared", alloc_blk, 0);
    tick();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule